// File: doc/BRIEF.md
# External Bus Ownership Controller

This block lets a host controller take over, and later hand back, the address and data bus of an attached 8-bit processor. It drives the processor's active-low reset and bus-request lines. It watches the processor's active-low bus-acknowledge line. It also produces one output enable that the host's address and strobe drivers use. The host gives one of four commands: reset, request, release or restart. The block walks the processor through the matching handshake and reports which of four ownership states it has reached.

There are two "owned" states. One is entered from a processor held in reset. The other is entered from a processor that is running. Releasing the first puts the processor back into reset. Releasing the second lets it carry on running. From the first owned state the host can also restart the processor: reset is pulsed while the bus request stays asserted, so the host still holds the bus when the processor comes out of reset. Bus read and write cycles, and the processor clock, belong to other blocks.

Top module: `bus_owner_ctrl`

## Requirements
- R1: After `rst_n` is deasserted, `own_state` is 0 (RESET), `proc_rst_n` is 0, `busreq_n` is 1, `bus_oe` is 0 and `busy` is 0. The `own_state` encoding is 0 = RESET, 1 = RESET_ACQUIRED, 2 = RUNNING, 3 = RUNNING_ACQUIRED.
- R2: A reset command (`cmd` = 0 with `cmd_valid`) is accepted in every state, including while `busy` is high. On the next clock `own_state` is 0, `proc_rst_n` is 0, `busreq_n` is 1, `bus_oe` is 0 and `busy` is 0.
- R3: A request command (`cmd` = 1) in RESET first drives `busreq_n` low for one cycle while `proc_rst_n` is still low. `proc_rst_n` goes high in the next cycle. The block then waits for acknowledge and ends in RESET_ACQUIRED with `bus_oe` = 1, `proc_rst_n` = 1 and `busreq_n` = 0.
- R4: A request command in RUNNING drives `busreq_n` low and keeps `proc_rst_n` high. After acknowledge it ends in RUNNING_ACQUIRED with `bus_oe` = 1.
- R5: A release command (`cmd` = 2) in RESET_ACQUIRED gives RESET: `bus_oe` = 0, `proc_rst_n` = 0, `busreq_n` = 1. In RUNNING_ACQUIRED it gives RUNNING: `bus_oe` = 0, `proc_rst_n` = 1, `busreq_n` = 1.
- R6: A restart command (`cmd` = 3) in RESET_ACQUIRED drops `bus_oe` and holds `busreq_n` low. It then drives `proc_rst_n` low for `PULSE_CYCLES` cycles, or longer until acknowledge has been seen inactive. After that it waits for acknowledge and ends in RUNNING_ACQUIRED.
- R7: `bus_oe` never rises unless the synchronized acknowledge was low. While acknowledge stays high, `bus_oe` stays low and `busy` stays high.
- R8: A command that is not valid in the current state is ignored, and so is any command other than reset while `busy` is high. `own_state` and the line outputs do not change. The ignored cases are: request in an owned state, release in a non-owned state, and restart anywhere except RESET_ACQUIRED.
- R9: `ack_n` passes through two flops. When `ack_n` falls during a wait, `bus_oe` rises at the third rising clock edge after the fall.
- R10: `busy` is high from the clock after an accepted request or restart until the owned state is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd | input | 2 | 0 reset, 1 request, 2 release, 3 restart |
| ack_n | input | 1 | Processor bus acknowledge, active low, asynchronous |
| proc_rst_n | output | 1 | Processor reset, active low |
| busreq_n | output | 1 | Processor bus request, active low |
| bus_oe | output | 1 | Enable for host address and strobe drivers |
| own_state | output | 2 | Ownership state (encoding in R1) |
| busy | output | 1 | Handshake in progress |

## Verification
The hardest case to reach is a handshake stuck waiting for an acknowledge that never comes. In normal use the processor model grants within a few cycles, so this case does not arise on its own. The bench therefore has a manual override on `ack_n`. It holds the acknowledge inactive to freeze the block mid-handshake, sends commands that must be ignored or must abort it, and then drops the acknowledge at a known edge to measure the synchronizer latency. The same override keeps the restart's reset pulse at exactly its minimum width.

// File: rtl/bus_owner_ctrl.sv
module bus_owner_ctrl #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic       ack_n,
  output logic       proc_rst_n,
  output logic       busreq_n,
  output logic       bus_oe,
  output logic [1:0] own_state,
  output logic       busy
);
  localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [1:0] C_RESET = 2'd0, C_REQ = 2'd1, C_REL = 2'd2, C_RESTART = 2'd3;
  localparam logic [1:0] S_RST = 2'd0, S_RST_ACQ = 2'd1, S_RUN = 2'd2, S_RUN_ACQ = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_ARM, PH_PULSE, PH_WAIT} phase_t;

  phase_t          ph;
  logic [1:0]      own, tgt;
  logic [CW-1:0]   cnt;
  logic [1:0]      ack_sync;
  logic            ack_s;

  assign ack_s = ack_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own      <= S_RST;
      tgt      <= S_RST;
      ph       <= PH_IDLE;
      cnt      <= '0;
      ack_sync <= 2'b11;
    end else begin
      ack_sync <= {ack_sync[0], ack_n};
      if (cmd_valid && cmd == C_RESET) begin
        own <= S_RST;
        ph  <= PH_IDLE;
      end else begin
        case (ph)
          PH_IDLE:
            if (cmd_valid) begin
              case (cmd)
                C_REQ:
                  if (own == S_RST) begin
                    ph  <= PH_ARM;
                    tgt <= S_RST_ACQ;
                  end else if (own == S_RUN) begin
                    ph  <= PH_WAIT;
                    tgt <= S_RUN_ACQ;
                  end
                C_REL:
                  if (own[0]) own <= {own[1], 1'b0};
                C_RESTART:
                  if (own == S_RST_ACQ) begin
                    ph  <= PH_PULSE;
                    tgt <= S_RUN_ACQ;
                    cnt <= CW'(PULSE_CYCLES - 1);
                  end
                default: ;
              endcase
            end
          PH_ARM:   ph <= PH_WAIT;
          PH_PULSE:
            if (cnt == '0) begin
              if (ack_s) ph <= PH_WAIT;
            end else begin
              cnt <= cnt - 1'b1;
            end
          PH_WAIT:
            if (!ack_s) begin
              own <= tgt;
              ph  <= PH_IDLE;
            end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy       = (ph != PH_IDLE);
  assign own_state  = own;
  assign proc_rst_n = (ph == PH_IDLE) ? (own != S_RST) : (ph == PH_WAIT);
  assign busreq_n   = (ph == PH_IDLE) ? !own[0] : 1'b0;
  assign bus_oe     = (ph == PH_IDLE) && own[0];

  assert_reset_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == C_RESET |=> own_state == S_RST && !proc_rst_n && busreq_n && !bus_oe && !busy);

  assert_oe_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> !$past(ack_sync[1]));

  assert_oe_with_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !busreq_n && proc_rst_n);

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid && cmd != C_RESET && ph != PH_WAIT |=> $stable(own_state));

  assert_bad_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid && cmd == C_REL && !own_state[0] |=> $stable(own_state) && !busy);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid && cmd == C_REL && own_state == S_RUN_ACQ |=> own_state == S_RUN && proc_rst_n && busreq_n);
endmodule

// File: tb/bus_owner_ctrl_tb_top.sv
module bus_owner_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;

  logic clk = 0, rst_n = 0, cmd_valid = 0, ack_n;
  logic [1:0] cmd = 0;
  logic proc_rst_n, busreq_n, bus_oe, busy;
  logic [1:0] own_state;
  logic man_en = 0, man_ack = 1;
  logic [2:0] dly = 3'b111;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) dly <= {dly[1:0], busreq_n | !proc_rst_n};
  assign ack_n = man_en ? man_ack : dly[2];

  bus_owner_ctrl #(.PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .ack_n(ack_n),
    .proc_rst_n(proc_rst_n), .busreq_n(busreq_n), .bus_oe(bus_oe),
    .own_state(own_state), .busy(busy));

  // {cmd, expected state, proc_rst_n, busreq_n, bus_oe}
  localparam logic [6:0] VEC [15] = '{
    7'b01_01_1_0_1, 7'b10_00_0_1_0, 7'b10_00_0_1_0, 7'b11_00_0_1_0,
    7'b01_01_1_0_1, 7'b01_01_1_0_1, 7'b11_11_1_0_1, 7'b11_11_1_0_1,
    7'b10_10_1_1_0, 7'b10_10_1_1_0, 7'b11_10_1_1_0, 7'b01_11_1_0_1,
    7'b00_00_0_1_0, 7'b01_01_1_0_1, 7'b00_00_0_1_0};

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1; cmd = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic outs(input int st, input int rs, input int br, input int oe, input string req);
    check(own_state, st, {req, " state"});
    check(proc_rst_n, rs, {req, " proc_rst_n"});
    check(busreq_n, br, {req, " busreq_n"});
    check(bus_oe, oe, {req, " bus_oe"});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    outs(0, 0, 1, 0, "R1");
    check(busy, 0, "R1 busy");

    // table walk covering R2 R3 R4 R5 R6 R8
    for (int k = 0; k < 15; k++) begin
      issue(VEC[k][6:5]);
      settle();
      outs(VEC[k][4:3], VEC[k][2], VEC[k][1], VEC[k][0], "R3 R4 R5 R6 R8 table");
    end

    // R3 ordering and R10
    issue(2'd1);
    check(busreq_n, 0, "R3 early busreq_n");
    check(proc_rst_n, 0, "R3 reset still held");
    check(busy, 1, "R10 busy");
    @(negedge clk);
    check(proc_rst_n, 1, "R3 reset released");
    settle();
    outs(1, 1, 0, 1, "R3 owned");

    // R6 pulse width with manual acknowledge
    man_en = 1; man_ack = 1;
    issue(2'd3);
    check(bus_oe, 0, "R6 oe dropped");
    n = 0;
    while (!proc_rst_n && n < 50) begin
      n++;
      if (busreq_n) check(busreq_n, 0, "R6 busreq held");
      @(negedge clk);
    end
    check(n, PULSE, "R6 pulse width");
    repeat (10) @(negedge clk);
    check(bus_oe, 0, "R7 oe while no ack");
    check(busy, 1, "R7 busy while no ack");
    issue(2'd2);
    check(own_state, 1, "R8 release while busy");
    check(busy, 1, "R8 still busy");
    man_ack = 0;
    @(negedge clk); check(bus_oe, 0, "R9 sync stage 1");
    @(negedge clk); check(bus_oe, 0, "R9 sync stage 2");
    @(negedge clk); check(bus_oe, 1, "R9 oe after sync");
    check(own_state, 3, "R6 final state");
    man_en = 0;
    repeat (4) @(negedge clk);

    issue(2'd2);
    settle();
    outs(2, 1, 1, 0, "R5 to running");

    // R2 abort during wait, R4 pending
    man_en = 1; man_ack = 1;
    issue(2'd1);
    check(busreq_n, 0, "R4 request");
    check(proc_rst_n, 1, "R4 reset stays high");
    repeat (5) @(negedge clk);
    check(busy, 1, "R7 waiting");
    issue(2'd0);
    outs(0, 0, 1, 0, "R2 abort");
    check(busy, 0, "R2 busy cleared");
    man_en = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule